// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave that keeps six 8-bit configuration registers for a clock generator. It runs on a fast system clock. It oversamples the serial clock and data lines and detects bus START and STOP conditions. It pulls the data line low through an output-enable pin, and the pad outside the block turns that pin into an open-drain driver. The register contents leave the block on a flat bus that feeds the rest of the chip.

The block has no sub-address. A write sends the device address, then a command byte and a length byte, then data. The slave acknowledges the command and length bytes and throws both away. The data bytes then fill the registers from byte 0 upward, and the controller may stop after any complete byte. A read sends the device address. The slave answers with a length byte and then the registers in ascending order. Each transfer starts again at byte 0.

Top module: `cfgslv_top`

## Requirements
- R1: The slave responds to the 7-bit address 0x69, which gives the address byte 0xD2 for a write and 0xD3 for a read (bit 0 is the direction, 1 = read). It pulls SDA low in the ninth bit of a matching address byte.
- R2: In a write, the slave acknowledges the two bytes that follow the address and stores neither of them in any register.
- R3: The write data bytes that follow load register 0, then 1, and so on up to 5. Each byte is acknowledged. Byte i of the register bus is `cfgRegs[8*i+7:8*i]`.
- R4: A STOP after any complete data byte leaves the registers written so far with their new values and all others unchanged.
- R5: In a read, the slave sends the value 6 first, then registers 0 to 5 in order. All bytes go MSB first, and SDA is released during the controller's acknowledge bit.
- R6: After reset, registers 0 to 5 hold 0x00, 0xFF, 0xFF, 0xF0, 0x3C and 0xA5.
- R7: When the address does not match, SDA stays released for the whole transfer and no register changes.
- R8: Write data bytes past register 5 are acknowledged and discarded. Read bytes past register 5 return 0xFF.
- R9: A not-acknowledge from the controller during a read makes the slave release SDA until the next STOP or START.
- R10: A START or STOP at any bit position aborts the transfer in progress. After a START the next byte is taken as an address byte.
- R11: The slave changes its SDA drive only while SCL is low. It holds the acknowledge low from the SCL fall after the eighth bit to the SCL fall after the ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | High pulls the data line low; low releases it |
| cfgRegs | output | 48 | Register bytes, byte i at bits 8*i+7 to 8*i |

## Verification
A bit counter that is one step off shows up on the bus at once. The acknowledge arrives one bit early or late, so the controller reads a missing ACK at the end of the same byte, or the slave pulls SDA low inside the next data byte. A byte index that is wrong by one moves every later register. A readback then shows a rotated pattern in the first byte after the length byte, or the length byte itself is wrong. If the transaction state survives a STOP or START, the next transfer goes wrong within its first byte: the slave either gives no address acknowledge or drives SDA when it should not. The bench counts SDA drive cycles during these windows to catch a wrong drive.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_WAIT
  } busState_e;

  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic regWrite;
  } strobe_t;
endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD    <= sclPipe[STAGES-1];
      sdaD    <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS && !sclD;
  assign sclFall  = !sclS && sclD;
  assign startDet = sclS && sclD && sdaD && !sdaS;
  assign stopDet  = sclS && sclD && !sdaD && sdaS;
endmodule

// File: rtl/cfgslv_ctrl.sv
module cfgslv_ctrl
  import cfgslv_pkg::*;
#(
  parameter int          NUM_REGS = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int          IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic             sdaS,
  input  logic [7:0]       rxByte,
  output strobe_t          strb,
  output logic [IDX_W-1:0] slotIdx,
  output logic             ackDrive,
  output logic             txActive
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] SKIP    = IDX_W'(2);

  busState_e        state;
  logic [3:0]       bitCnt;
  logic             inAck, ackOn, readDir;
  logic [IDX_W-1:0] byteIdx, nextIdx;
  logic             active, frameBit, byteEnd, ackEnd, addrHit;

  assign active   = (state == ST_ADDR) || (state == ST_WRITE) || (state == ST_READ);
  assign frameBit = active && sclRise && !inAck && (bitCnt < 4'd8);
  assign byteEnd  = active && sclFall && !inAck && (bitCnt == 4'd8);
  assign ackEnd   = active && sclFall && inAck;
  assign addrHit  = (rxByte[7:1] == DEV_ADDR);
  assign nextIdx  = (state == ST_ADDR) ? '0 :
                    (byteIdx == IDX_MAX) ? byteIdx : byteIdx + 1'b1;

  always_comb begin
    strb.rxShift  = frameBit;
    strb.txShift  = (state == ST_READ) && sclFall && !inAck &&
                    (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    strb.txLoad   = ackEnd && (((state == ST_ADDR) && readDir) || (state == ST_READ));
    strb.regWrite = byteEnd && (state == ST_WRITE) && (byteIdx >= SKIP);
    slotIdx       = strb.regWrite ? byteIdx - SKIP : nextIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      ackOn   <= 1'b0;
      readDir <= 1'b0;
      byteIdx <= '0;
    end else if (startDet || stopDet) begin
      state   <= startDet ? ST_ADDR : ST_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      ackOn   <= 1'b0;
      byteIdx <= '0;
    end else if (active) begin
      if (frameBit) bitCnt <= bitCnt + 4'd1;
      if (sclRise && inAck && (state == ST_READ) && sdaS) begin
        state <= ST_WAIT;
        inAck <= 1'b0;
      end
      if (byteEnd) begin
        inAck <= 1'b1;
        unique case (state)
          ST_ADDR: begin
            if (addrHit) begin
              ackOn   <= 1'b1;
              readDir <= rxByte[0];
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_WRITE: ackOn <= 1'b1;
          default:  ackOn <= 1'b0;
        endcase
      end
      if (ackEnd) begin
        inAck   <= 1'b0;
        ackOn   <= 1'b0;
        bitCnt  <= '0;
        byteIdx <= nextIdx;
        if (state == ST_ADDR) state <= readDir ? ST_READ : ST_WRITE;
      end
    end
  end

  assign ackDrive = inAck && ackOn;
  assign txActive = (state == ST_READ) && !inAck;
endmodule

// File: rtl/cfgslv_data.sv
module cfgslv_data
  import cfgslv_pkg::*;
#(
  parameter int                      NUM_REGS = 6,
  parameter int                      IDX_W    = 4,
  parameter logic [8*NUM_REGS-1:0]   DEFAULTS = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaS,
  input  strobe_t               strb,
  input  logic [IDX_W-1:0]      slotIdx,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [8*NUM_REGS-1:0] regsFlat
);
  logic [7:0] regs [NUM_REGS];
  logic [7:0] rxSh, txSh, txByte;

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        regs[i] <= DEFAULTS[8*i +: 8];
      else if (strb.regWrite && slotIdx == IDX_W'(i))  regs[i] <= rxSh;
    end
    assign regsFlat[8*i +: 8] = regs[i];
  end

  always_comb begin
    txByte = 8'hFF;
    if (slotIdx == '0) txByte = 8'(NUM_REGS);
    for (int i = 0; i < NUM_REGS; i++)
      if (slotIdx == IDX_W'(i + 1)) txByte = regs[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
      txSh <= 8'hFF;
    end else begin
      if (strb.rxShift) rxSh <= {rxSh[6:0], sdaS};
      if (strb.txLoad)       txSh <= txByte;
      else if (strb.txShift) txSh <= {txSh[6:0], 1'b1};
    end
  end

  assign rxByte = rxSh;
  assign txBit  = txSh[7];
endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top
  import cfgslv_pkg::*;
#(
  parameter int                    NUM_REGS    = 6,
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter logic [8*NUM_REGS-1:0] DEFAULTS    = 48'hA5_3C_F0_FF_FF_00,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [8*NUM_REGS-1:0] cfgRegs
);
  localparam int IDX_W = $clog2(NUM_REGS + 4);

  logic             sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [7:0]       rxByte;
  logic             txBit, ackDrive, txActive;
  logic [IDX_W-1:0] slotIdx;
  strobe_t          strb;

  cfgslv_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  cfgslv_ctrl #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .rxByte(rxByte),
    .strb(strb), .slotIdx(slotIdx), .ackDrive(ackDrive), .txActive(txActive)
  );

  cfgslv_data #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DEFAULTS(DEFAULTS)) uData (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strb(strb), .slotIdx(slotIdx),
    .rxByte(rxByte), .txBit(txBit), .regsFlat(cfgRegs)
  );

  assign sdaOe = ackDrive || (txActive && !txBit);
endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk #(
  parameter int NUM_REGS = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclS,
  input logic                  stopDet,
  input logic                  regWrite,
  input logic                  ackDrive,
  input logic                  txActive,
  input logic                  sdaOe,
  input logic [8*NUM_REGS-1:0] cfgRegs
);
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe)); // R11

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R10

  AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> ackDrive); // R3

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrite) |-> $stable(cfgRegs)); // R2

  AST_ACK_EXCLUDES_TX: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && txActive)); // R5
endmodule

bind cfgslv_top cfgslv_chk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .stopDet(stopDet),
  .regWrite(strb.regWrite), .ackDrive(ackDrive), .txActive(txActive),
  .sdaOe(sdaOe), .cfgRegs(cfgRegs)
);

// File: tb/tb_cfgslv_top.sv
module tb_cfgslv_top;
  localparam int Q = 10;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe;
  logic [8*N-1:0] cfgRegs;
  wire sdaLine = sdaOe ? 1'b0 : sdaM;

  cfgslv_top dut (.clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
                  .sdaOe(sdaOe), .cfgRegs(cfgRegs));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, oeCount = 0;
  logic [7:0] expRegs [N];
  logic [7:0] wrData [16];
  logic [7:0] rdData [16];
  logic [7:0] rdCount;
  int nackSeen;

  always @(negedge clk) if (sdaOe) oeCount++;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [8*N-1:0] packExp();
    logic [8*N-1:0] v;
    for (int i = 0; i < N; i++) v[8*i +: 8] = expRegs[i];
    return v;
  endfunction

  function automatic logic [7:0] expRead(input int idx);
    if (idx == 0) return 8'd6;
    if (idx <= N) return expRegs[idx-1];
    return 8'hFF;
  endfunction

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic bitXfer(input logic b, output logic s);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); s = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitXfer(d[i], s);
    bitXfer(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bitXfer(1'b1, s); d[i] = s; end
    bitXfer(mAck ? 1'b0 : 1'b1, s);
  endtask

  // full write: address, two dummies, nData bytes from wrData
  task automatic doWrite(input int nData, input string req);
    bit a;
    busStart();
    sendByte(8'hD2, a); check(a, "R1 write address ack", a, 1);
    sendByte(8'($urandom), a); check(a, "R2 command byte ack", a, 1);
    sendByte(8'($urandom), a); check(a, "R2 length byte ack", a, 1);
    for (int i = 0; i < nData; i++) begin
      sendByte(wrData[i], a);
      check(a, req, a, 1);
      check(!sdaOe, "R11 ack released after ninth fall", sdaOe, 0);
      if (i < N) expRegs[i] = wrData[i];
    end
    busStop();
  endtask

  task automatic doRead(input int nData, input string req);
    bit a;
    busStart();
    sendByte(8'hD3, a); check(a, "R1 read address ack", a, 1);
    recvByte(1'b1, rdCount);
    check(rdCount == 8'd6, "R5 length byte", rdCount, 6);
    for (int i = 0; i < nData; i++) begin
      recvByte(i != nData - 1, rdData[i]);
      check(rdData[i] == expRead(i + 1), req, rdData[i], expRead(i + 1));
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishUp();
  end

  initial begin
    bit a;
    logic [7:0] d;
    int oeBefore;
    void'($urandom(32'd4242));
    expRegs[0] = 8'h00; expRegs[1] = 8'hFF; expRegs[2] = 8'hFF;
    expRegs[3] = 8'hF0; expRegs[4] = 8'h3C; expRegs[5] = 8'hA5;
    repeat (5) @(negedge clk);
    check(cfgRegs == packExp(), "R6 reset defaults", cfgRegs, packExp());
    check(!sdaOe, "R6 SDA released in reset", sdaOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(cfgRegs == packExp(), "R6 defaults after reset", cfgRegs, packExp());

    doRead(N, "R6 R5 default readback");

    // full random write then read back
    for (int i = 0; i < N; i++) wrData[i] = 8'($urandom);
    doWrite(N, "R3 data byte ack");
    check(cfgRegs == packExp(), "R3 R2 registers after full write", cfgRegs, packExp());
    doRead(N, "R5 readback");

    // partial write
    for (int i = 0; i < 3; i++) wrData[i] = 8'($urandom) ^ 8'h5A;
    doWrite(3, "R4 partial write ack");
    check(cfgRegs == packExp(), "R4 partial write keeps rest", cfgRegs, packExp());

    // stop right after the dummies: nothing written
    doWrite(0, "R2 no data");
    check(cfgRegs == packExp(), "R2 dummies not stored", cfgRegs, packExp());

    // mismatched address, both directions
    for (int k = 0; k < 2; k++) begin
      logic [7:0] badAddr;
      badAddr = {7'h68 - 7'(k * 3), 1'(k)};
      oeBefore = oeCount;
      busStart();
      sendByte(badAddr, a); check(!a, "R7 no ack on other address", a, 0);
      sendByte(8'h11, a);
      sendByte(8'h00, a);
      busStop();
      check(oeCount == oeBefore, "R7 SDA never driven", oeCount - oeBefore, 0);
      check(cfgRegs == packExp(), "R7 registers unchanged", cfgRegs, packExp());
    end

    // overlong write
    for (int i = 0; i < 8; i++) wrData[i] = 8'($urandom);
    doWrite(8, "R8 extra byte ack");
    check(cfgRegs == packExp(), "R8 extra write bytes discarded", cfgRegs, packExp());
    doRead(8, "R8 read past end gives FF");

    // controller NACK during read
    busStart();
    sendByte(8'hD3, a); check(a, "R1 read address ack", a, 1);
    recvByte(1'b1, d);
    recvByte(1'b0, d);
    check(d == expRegs[0], "R9 byte before NACK", d, expRegs[0]);
    oeBefore = oeCount;
    recvByte(1'b1, d);
    check(oeCount == oeBefore, "R9 released after NACK", oeCount - oeBefore, 0);
    check(d == 8'hFF, "R9 bus reads idle after NACK", d, 8'hFF);
    busStop();

    // START in the middle of a byte aborts
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    for (int i = 0; i < 3; i++) begin logic s; bitXfer(1'b0, s); end
    for (int i = 0; i < N; i++) wrData[i] = 8'($urandom);
    doWrite(N, "R10 write after restart");
    check(cfgRegs == packExp(), "R10 registers after restart", cfgRegs, packExp());

    // STOP in the middle of a data byte aborts
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    for (int i = 0; i < 4; i++) begin logic s; bitXfer(1'b1, s); end
    sclM = 1'b0; waitQ();
    busStop();
    check(cfgRegs == packExp(), "R10 STOP mid byte stores nothing", cfgRegs, packExp());
    doRead(N, "R10 read after aborted write");

    // random partial writes with readback
    for (int r = 0; r < 4; r++) begin
      int len;
      len = int'($urandom_range(1, 7));
      for (int i = 0; i < len; i++) wrData[i] = 8'($urandom);
      doWrite(len, "R3 random write ack");
      check(cfgRegs == packExp(), "R4 random partial write", cfgRegs, packExp());
      doRead(N, "R5 random readback");
    end

    finishUp();
  end
endmodule